// File: doc/BRIEF.md
# SCL Divisor Search

This unit chooses the two clock divider settings of a serial bus controller, a 2-bit A and a 6-bit B. The resulting SCL rate is the input clock divided by 22·(A+1)·(B+1). The unit picks the pair that brings this rate closest to a requested target without going above it.

On a start strobe it samples the input clock frequency and the target frequency, both unsigned integers in Hz. It then runs a fixed sequence of integer divisions on one shared bit-serial divider. The first division is a range check. After that, for every candidate A it performs one division to size B and a second to find the rate that pair gives. When the search ends, the unit pulses done for one cycle and holds the chosen A, B, the achieved rate and an error flag until the next search finishes. The usual target is 400 kHz, which is also the highest rate the bus supports.

Top module: `scl_div_search`

## Requirements
- R1: The range quotient q0 = floor(Fin / (22·Ft)) is computed first. If q0 is 0 or above 256 (Ft = 0 counts as out of range), the result is bad_ratio = 1 with div_a = 0, div_b = 0 and f_actual = 0.
- R2: For each A from 0 to 3 the B factor is ceil(Fin / (22·Ft·(A+1))). A candidate whose factor is outside 1..64 is skipped. Otherwise its B is the factor minus 1.
- R3: A candidate's rate is floor(Fin / (22·(A+1)·(B+1))). A candidate whose rate exceeds Ft is discarded, so a reported f_actual never exceeds Ft.
- R4: A surviving candidate replaces the best so far only when Ft minus its rate is strictly smaller than the best error, which starts at the maximum value. A tie therefore keeps the smaller A.
- R5: When the range check passes but no candidate survives, the result is div_a = 0, div_b = 0, f_actual = Ft and bad_ratio = 0.
- R6: done is high for exactly one cycle per search. In that cycle div_a, div_b, f_actual and bad_ratio carry the new result, and they keep it until the next search completes.
- R7: A start seen while a search is running is ignored. The running search keeps the operands it sampled, and no extra done follows.
- R8: After reset, done, bad_ratio, div_a, div_b and f_actual are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search; sampled only when idle |
| f_in | input | FW | Input clock frequency in Hz |
| f_target | input | FW | Requested SCL frequency in Hz |
| div_a | output | 2 | Chosen first divider |
| div_b | output | 6 | Chosen second divider |
| f_actual | output | FW | SCL rate of the chosen pair, or the target when nothing fits |
| done | output | 1 | One-cycle completion pulse |
| bad_ratio | output | 1 | Target out of range for the divider chain |

## Verification
The sweep places Fin one below, exactly on and one above multiples 22·Ft·k, for k around 1, 64 and 256. These are the edges where the ceiling, the skip window and the range limit change their answer. An off-by-one in the B ceiling would show up as a B one too small and a rate above the target. A range check done with greater-or-equal would reject q0 = 256. Fin = 22·Ft·256 + 1 passes the range check yet leaves no candidate, so a design that loses that path would report zeros instead of the target. Ties between A values that give the same rate catch a non-strict compare, which would report a larger A. A second start sent mid-search catches a design that restarts or reloads its operands.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  // Search sequencer states; GO states launch one division on the shared divider.
  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_RATIO_GO   = 4'd1,
    ST_RATIO_WAIT = 4'd2,
    ST_B_GO       = 4'd3,
    ST_B_WAIT     = 4'd4,
    ST_F_GO       = 4'd5,
    ST_F_WAIT     = 4'd6,
    ST_NEXT       = 4'd7,
    ST_DONE       = 4'd8
  } search_st_e;

endpackage

// File: rtl/scl_seq_divider.sv
// Restoring divider, one quotient bit per cycle, NW cycles per division.
module scl_seq_divider #(
  parameter int NW = 32,
  parameter int DW = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);
  localparam int PW = NW + DW;

  logic [NW-1:0] num_q;
  logic [NW-1:0] shf_q;
  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial;
  logic          fits;
  logic          step_last;

  always_comb begin
    trial = {rem_q, shf_q[NW-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  assign step_last = busy && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      shf_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        num_q <= num;
        shf_q <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        shf_q <= {shf_q[NW-2:0], fits};
        rem_q <= fits ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (step_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = shf_q;
  assign rem = rem_q;

  // R2
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && den_q != '0) |->
      ((PW'(quo) * PW'(den_q) + PW'(rem_q)) == PW'(num_q)) && (rem_q < den_q));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

endmodule

// File: rtl/scl_best_keeper.sv
// Holds the closest not-faster candidate seen in the current search.
module scl_best_keeper #(
  parameter int FW = 32,
  parameter int AW = 2,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          offer,
  input  logic [AW-1:0] cand_a,
  input  logic [BW-1:0] cand_b,
  input  logic [FW-1:0] cand_f,
  input  logic [FW-1:0] target,
  output logic          best_valid,
  output logic [AW-1:0] best_a,
  output logic [BW-1:0] best_b,
  output logic [FW-1:0] best_f
);
  logic [FW-1:0] best_err;
  logic [FW-1:0] cand_err;
  logic          not_fast;
  logic          take;

  assign not_fast = (cand_f <= target);
  assign cand_err = target - cand_f;
  assign take     = offer && not_fast && (cand_err < best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err   <= '1;
      best_valid <= 1'b0;
      best_a     <= '0;
      best_b     <= '0;
      best_f     <= '0;
    end else if (clear) begin
      best_err   <= '1;
      best_valid <= 1'b0;
      best_a     <= '0;
      best_b     <= '0;
      best_f     <= '0;
    end else if (take) begin
      best_err   <= cand_err;
      best_valid <= 1'b1;
      best_a     <= cand_a;
      best_b     <= cand_b;
      best_f     <= cand_f;
    end
  end

  // R3
  best_not_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (best_f <= target));

  // R4
  best_err_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (best_err <= $past(best_err)));

endmodule

// File: rtl/scl_div_search.sv
module scl_div_search
  import scl_div_pkg::*;
#(
  parameter int FW        = 32,
  parameter int A_CNT     = 4,
  parameter int B_MAX     = 64,
  parameter int CLK_SCALE = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [FW-1:0]              f_in,
  input  logic [FW-1:0]              f_target,
  output logic [$clog2(A_CNT)-1:0]   div_a,
  output logic [$clog2(B_MAX)-1:0]   div_b,
  output logic [FW-1:0]              f_actual,
  output logic                       done,
  output logic                       bad_ratio
);
  localparam int AW          = $clog2(A_CNT);
  localparam int BW          = $clog2(B_MAX);
  localparam int DW          = FW + $clog2(CLK_SCALE * A_CNT);
  localparam int RATIO_LIMIT = A_CNT * B_MAX;

  // Denominators of the three kinds of division.
  function automatic logic [DW-1:0] range_den(input logic [FW-1:0] ft);
    return DW'(ft) * DW'(CLK_SCALE);
  endfunction

  function automatic logic [DW-1:0] b_den(input logic [FW-1:0] ft, input logic [AW-1:0] a);
    return range_den(ft) * (DW'(a) + DW'(1));
  endfunction

  function automatic logic [DW-1:0] rate_den(input logic [AW-1:0] a, input logic [BW-1:0] b);
    return DW'(CLK_SCALE) * (DW'(a) + DW'(1)) * (DW'(b) + DW'(1));
  endfunction

  function automatic logic [FW:0] round_up(input logic [FW-1:0] q, input logic [DW-1:0] r);
    return {1'b0, q} + (FW+1)'(r != '0);
  endfunction

  search_st_e    st_q;
  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [FW-1:0] fin_q;
  logic [FW-1:0] ft_q;
  logic          fail_q;

  logic          div_go;
  logic [DW-1:0] div_den;
  logic          div_busy;
  logic          div_done;
  logic [FW-1:0] div_quo;
  logic [DW-1:0] div_rem;

  logic          ratio_bad;
  logic [FW:0]   b_factor;
  logic          b_in_range;
  logic          last_a;
  logic          keep_clear;
  logic          keep_offer;
  logic          best_valid;
  logic [AW-1:0] best_a;
  logic [BW-1:0] best_b;
  logic [FW-1:0] best_f;

  always_comb begin
    div_go = (st_q == ST_RATIO_GO) || (st_q == ST_B_GO) || (st_q == ST_F_GO);
    case (st_q)
      ST_B_GO: div_den = b_den(ft_q, a_q);
      ST_F_GO: div_den = rate_den(a_q, b_q);
      default: div_den = range_den(ft_q);
    endcase
  end

  assign ratio_bad  = (div_quo == '0) || (div_quo > FW'(RATIO_LIMIT));
  assign b_factor   = round_up(div_quo, div_rem);
  assign b_in_range = (b_factor != '0) && (b_factor <= (FW+1)'(B_MAX));
  assign last_a     = (a_q == AW'(A_CNT - 1));
  assign keep_clear = (st_q == ST_IDLE) && start;
  assign keep_offer = (st_q == ST_F_WAIT) && div_done;

  scl_seq_divider #(.NW(FW), .DW(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (fin_q),
    .den  (div_den),
    .busy (div_busy),
    .done (div_done),
    .quo  (div_quo),
    .rem  (div_rem)
  );

  scl_best_keeper #(.FW(FW), .AW(AW), .BW(BW)) u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (keep_clear),
    .offer     (keep_offer),
    .cand_a    (a_q),
    .cand_b    (b_q),
    .cand_f    (div_quo),
    .target    (ft_q),
    .best_valid(best_valid),
    .best_a    (best_a),
    .best_b    (best_b),
    .best_f    (best_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      a_q       <= '0;
      b_q       <= '0;
      fin_q     <= '0;
      ft_q      <= '0;
      fail_q    <= 1'b0;
      div_a     <= '0;
      div_b     <= '0;
      f_actual  <= '0;
      done      <= 1'b0;
      bad_ratio <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            fin_q  <= f_in;
            ft_q   <= f_target;
            fail_q <= 1'b0;
            a_q    <= '0;
            st_q   <= ST_RATIO_GO;
          end
        end
        ST_RATIO_GO: st_q <= ST_RATIO_WAIT;
        ST_RATIO_WAIT: begin
          if (div_done) begin
            if (ratio_bad) begin
              fail_q <= 1'b1;
              st_q   <= ST_DONE;
            end else begin
              st_q <= ST_B_GO;
            end
          end
        end
        ST_B_GO: st_q <= ST_B_WAIT;
        ST_B_WAIT: begin
          if (div_done) begin
            if (b_in_range) begin
              b_q  <= BW'(b_factor - (FW+1)'(1));
              st_q <= ST_F_GO;
            end else begin
              st_q <= ST_NEXT;
            end
          end
        end
        ST_F_GO: st_q <= ST_F_WAIT;
        ST_F_WAIT: begin
          if (div_done) st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (last_a) begin
            st_q <= ST_DONE;
          end else begin
            a_q  <= a_q + AW'(1);
            st_q <= ST_B_GO;
          end
        end
        ST_DONE: begin
          done <= 1'b1;
          if (fail_q) begin
            div_a     <= '0;
            div_b     <= '0;
            f_actual  <= '0;
            bad_ratio <= 1'b1;
          end else if (best_valid) begin
            div_a     <= best_a;
            div_b     <= best_b;
            f_actual  <= best_f;
            bad_ratio <= 1'b0;
          end else begin
            div_a     <= '0;
            div_b     <= '0;
            f_actual  <= ft_q;
            bad_ratio <= 1'b0;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  err_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad_ratio) |-> (div_a == '0 && div_b == '0 && f_actual == '0));

  // R3
  result_le_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_ratio) |-> (f_actual <= ft_q));

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && start) |=> ($stable(fin_q) && $stable(ft_q)));

  // R2
  div_idle_at_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

endmodule

// File: tb/tb_scl_div_search.sv
module tb_scl_div_search;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int RUN_LIMIT  = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] f_in = '0;
  logic [31:0] f_target = '0;
  logic [1:0]  div_a;
  logic [5:0]  div_b;
  logic [31:0] f_actual;
  logic        done;
  logic        bad_ratio;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_div_search dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .f_in     (f_in),
    .f_target (f_target),
    .div_a    (div_a),
    .div_b    (div_b),
    .f_actual (f_actual),
    .done     (done),
    .bad_ratio(bad_ratio)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Reference search written from the requirements in 64-bit arithmetic.
  task automatic model(input longint fin, input longint ft, output bit e_bad,
                       output longint e_a, output longint e_b, output longint e_f,
                       output bit e_none);
    longint best_err;
    e_bad = 1'b0; e_a = 0; e_b = 0; e_f = 0; e_none = 1'b0;
    if (ft == 0 || fin / (22 * ft) == 0 || fin / (22 * ft) > 256) begin
      e_bad = 1'b1;
      return;
    end
    best_err = 64'h7FFF_FFFF_FFFF_FFFF;
    e_none = 1'b1;
    for (int a = 0; a < 4; a++) begin
      longint step = 22 * ft * (a + 1);
      longint fac  = fin / step + ((fin % step) != 0 ? 1 : 0);
      longint rate;
      if (fac < 1 || fac > 64) continue;
      rate = fin / (22 * (a + 1) * fac);
      if (rate > ft) continue;
      if (ft - rate < best_err) begin
        best_err = ft - rate;
        e_a = a; e_b = fac - 1; e_f = rate; e_none = 1'b0;
      end
    end
    if (e_none) e_f = ft;
  endtask

  task automatic launch(input longint fin, input longint ft);
    @(negedge clk);
    start    = 1'b1;
    f_in     = 32'(fin);
    f_target = 32'(ft);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < RUN_LIMIT; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic compare(input longint fin, input longint ft, input string tag);
    bit e_bad, e_none;
    longint e_a, e_b, e_f;
    model(fin, ft, e_bad, e_a, e_b, e_f, e_none);
    check(bad_ratio == e_bad, e_bad ? "R1" : tag, "bad_ratio", longint'(bad_ratio), longint'(e_bad));
    check(div_a == e_a, e_bad ? "R1" : (e_none ? "R5" : "R4"), "div_a", longint'(div_a), e_a);
    check(div_b == e_b, e_bad ? "R1" : (e_none ? "R5" : "R2"), "div_b", longint'(div_b), e_b);
    check(f_actual == e_f, e_bad ? "R1" : (e_none ? "R5" : "R3"), "f_actual", longint'(f_actual), e_f);
  endtask

  task automatic one_case(input longint fin, input longint ft);
    bit seen;
    logic [31:0] held;
    launch(fin, ft);
    wait_done(seen);
    check(seen, "R6", "done seen", longint'(seen), 1);
    if (!seen) return;
    compare(fin, ft, "R6");
    held = f_actual;
    @(negedge clk);
    // R6: pulse lasts one cycle, result held afterwards
    check(done == 1'b0, "R6", "done width", longint'(done), 0);
    check(f_actual == held, "R6", "held f_actual", longint'(f_actual), longint'(held));
  endtask

  initial begin
    longint fts[6] = '{1, 3, 1000, 99999, 100000, 400000};
    longint ks[13] = '{1, 2, 3, 21, 22, 63, 64, 65, 88, 128, 255, 256, 257};
    bit seen;
    int extra;

    repeat (3) @(negedge clk);
    // R8: reset state
    check(done == 1'b0 && bad_ratio == 1'b0, "R8", "flags in reset", longint'({done, bad_ratio}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(div_a == 0 && div_b == 0, "R8", "dividers after reset", longint'({div_a, div_b}), 0);
    check(f_actual == 0, "R8", "f_actual after reset", longint'(f_actual), 0);

    // R1: direct out-of-range targets
    one_case(1000, 0);
    one_case(0, 400000);
    one_case(21, 1);
    one_case(64'hFFFF_FFFF, 64'h8000_0000);
    one_case(22 * 257, 1);

    // R2 R3 R4 R5: sweep around multiples of 22*Ft*k
    foreach (fts[i]) begin
      foreach (ks[j]) begin
        for (int d = -1; d <= 1; d++) begin
          longint fin = 22 * fts[i] * ks[j] + d;
          if (fin < 0 || fin > 64'hFFFF_FFFF) continue;
          one_case(fin, fts[i]);
        end
      end
    end

    // R4: ties resolve to smaller A (Fin = 22*12, Ft = 1 gives rate 1 for several A)
    one_case(22 * 12, 1);
    one_case(22 * 48 + 5, 2);

    // R7: a second start mid-search is ignored
    launch(111111111, 400000);
    repeat (5) @(negedge clk);
    start = 1'b1; f_in = 32'd5000; f_target = 32'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check(seen, "R7", "done after ignored start", longint'(seen), 1);
    compare(111111111, 400000, "R7");
    extra = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R7", "no extra done", longint'(extra), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule